// File: doc/BRIEF.md
# Variable-Length Frame Builder

This block turns buffered transmit words into variable-length link frames and hands them, one 16-bit word at a time, to a downstream serializer. A frame request arrives on its own valid/ready channel and carries the payload length, a label-enable flag with the label value, a checksum-enable flag and a one-bit data type. Once a request is taken, the builder sends a protected descriptor word. It then sends the label, if enabled. Next it passes the payload words through from the word channel, and last it sends an 8-bit checksum, if enabled. The checksum covers the label and the payload only.

The descriptor word carries a start-of-frame strobe, which the serializer uses to place a header mark on its sync channel. Backpressure on the output port stalls the builder at any point without losing or repeating a word.

The control is one state machine with five states:
- `ST_IDLE` waits for a frame request and moves to `ST_DESC` when one is accepted.
- `ST_DESC` moves, once its word is taken, to `ST_LABEL` if a label is present. Otherwise it moves to `ST_PAYLOAD` if the length is non-zero, then to `ST_CHECK` if the checksum is enabled, and otherwise back to `ST_IDLE`.
- `ST_LABEL` moves to `ST_PAYLOAD`, `ST_CHECK` or `ST_IDLE` by the same rules.
- `ST_PAYLOAD` leaves on the last payload word, to `ST_CHECK` or `ST_IDLE`.
- `ST_CHECK` returns to `ST_IDLE` once its word is taken.

Top module: `vlf_builder`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` and `pld_ready` are low and `frm_ready` is high.
- R2: The descriptor word holds a 12-bit code in bits 11:0, and bits 15:12 are zero.
  - The 7 information bits are d3..d0 = payload length, d4 = label present, d5 = checksum present and d6 = data type.
  - Code bits 10:0 are Hamming positions 1..11. Parity sits at positions 1, 2, 4 and 8; d0..d6 sit at positions 3, 5, 6, 7, 9, 10 and 11.
  - Each parity bit gives even parity over the positions whose index has that bit set.
  - Bit 11 is the even parity of bits 10:0.
- R3: The words of a frame leave in the order descriptor, label (only if enabled), payload words in arrival order (exactly the requested count, 0 to 15), checksum (only if enabled). No other word follows.
- R4: `out_sof` is high on the descriptor word and on no other word.
- R5: The checksum word carries, in bits 7:0, a CRC-8 with polynomial x^8+x^2+x+1 and initial value 0x00. It is computed MSB first over the label word (if present) and then the payload words. Bits 15:8 are zero.
- R6: A frame with length 0, no label and no checksum is exactly one descriptor word.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_sof` hold their values, and no word is lost or duplicated.
- R8: `frm_ready` is high only while no frame is in progress, and no output word is offered while it is high.
- R9: `pld_ready` is high only during the payload phase, where it follows `out_ready`. A payload word accepted on the word channel leaves in the same cycle as an output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame request valid |
| frm_ready | output | 1 | Frame request accepted |
| frm_len | input | 4 | Payload word count, 0 to 15 |
| frm_lbl_en | input | 1 | Label word present |
| frm_lbl | input | 16 | Label value |
| frm_crc_en | input | 1 | Checksum word present |
| frm_type | input | 1 | Data type bit |
| pld_valid | input | 1 | Payload word valid |
| pld_ready | output | 1 | Payload word accepted |
| pld_data | input | 16 | Payload word |
| out_valid | output | 1 | Frame word valid |
| out_ready | input | 1 | Downstream accepts frame word |
| out_data | output | 16 | Frame word |
| out_sof | output | 1 | Start of frame, marks the descriptor |

## Verification
The hold property on the output assumes the source keeps `pld_valid` and `pld_data` steady until `pld_ready` takes the word, because payload words pass straight through to `out_data`. It also assumes the source offers exactly the requested number of payload words per frame. The stimulus drives every word from a task that holds it until the handshake completes, and it supplies exactly `frm_len` words per request. Output backpressure is varied between always-ready, ready two cycles in three, and ready every other cycle. A directed case holds the descriptor under backpressure for several cycles.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

    function automatic int calc_par(input int n);
        int p;
        p = 0;
        while ((1 << p) < (n + p + 1)) p++;
        return p;
    endfunction

    localparam int LEN_W  = 4;
    localparam int INFO_W = LEN_W + 3;
    localparam int PAR_W  = calc_par(INFO_W);
    localparam int HAM_W  = INFO_W + PAR_W;
    localparam int CODE_W = HAM_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_LABEL,
        ST_PAYLOAD,
        ST_CHECK
    } vlf_state_e;

    typedef struct packed {
        logic             typ;
        logic             crc_en;
        logic             lbl_en;
        logic [LEN_W-1:0] len;
    } vlf_info_t;

    // Single-error-correcting code plus overall parity
    function automatic logic [CODE_W-1:0] ham_encode(input logic [INFO_W-1:0] info);
        logic [HAM_W-1:0] cw;
        logic             p;
        int               j;
        cw = '0;
        j  = 0;
        for (int pos = 1; pos <= HAM_W; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                cw[pos-1] = info[j];
                j++;
            end
        end
        for (int k = 0; k < PAR_W; k++) begin
            p = 1'b0;
            for (int pos = 1; pos <= HAM_W; pos++) begin
                if ((((pos >> k) & 1) == 1) && (pos != (1 << k)))
                    p = p ^ cw[pos-1];
            end
            cw[(1 << k) - 1] = p;
        end
        return {^cw, cw};
    endfunction

endpackage

// File: rtl/vlf_desc_enc.sv
module vlf_desc_enc
    import vlf_pkg::*;
(
    input  vlf_info_t          info,
    output logic [CODE_W-1:0]  code
);

    always_comb begin
        code = ham_encode(info);
    end

endmodule

// File: rtl/vlf_crc_acc.sv
module vlf_crc_acc #(
    parameter int               DATA_W = 16,
    parameter int               CRC_W  = 8,
    parameter logic [CRC_W-1:0] POLY   = 8'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              upd,
    input  logic [DATA_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);

    logic [CRC_W-1:0] crc_nxt;

    // Bit-serial shift, most significant data bit first, unrolled
    always_comb begin
        logic fb;
        crc_nxt = crc;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb      = crc_nxt[CRC_W-1] ^ din[i];
            crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0};
            if (fb) crc_nxt = crc_nxt ^ POLY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) crc <= '0;
        else if (upd)   crc <= crc_nxt;
    end

endmodule

// File: rtl/vlf_beat_cnt.sv
module vlf_beat_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/vlf_builder.sv
module vlf_builder
    import vlf_pkg::*;
#(
    parameter int               DATA_W   = 16,
    parameter int               CRC_W    = 8,
    parameter logic [CRC_W-1:0] CRC_POLY = 8'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    output logic              frm_ready,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_lbl_en,
    input  logic [DATA_W-1:0] frm_lbl,
    input  logic              frm_crc_en,
    input  logic              frm_type,
    input  logic              pld_valid,
    output logic              pld_ready,
    input  logic [DATA_W-1:0] pld_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof
);

    vlf_state_e        st_q, st_d;
    vlf_state_e        st_after_lbl, st_after_pld;
    vlf_info_t         info_q;
    logic [DATA_W-1:0] lbl_q;
    logic [CODE_W-1:0] desc_code;
    logic [CRC_W-1:0]  crc_val;
    logic [LEN_W-1:0]  beat;
    logic              frm_fire, out_fire, last_beat;
    logic              crc_upd, beat_inc;

    assign frm_fire  = frm_valid && frm_ready;
    assign out_fire  = out_valid && out_ready;
    assign last_beat = (beat == (info_q.len - 1'b1));
    assign crc_upd   = out_fire && ((st_q == ST_LABEL) || (st_q == ST_PAYLOAD));
    assign beat_inc  = out_fire && (st_q == ST_PAYLOAD);

    vlf_desc_enc u_desc (
        .info (info_q),
        .code (desc_code)
    );

    vlf_crc_acc #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY)
    ) u_crc (
        .clk (clk),
        .rst (rst),
        .clr (frm_fire),
        .upd (crc_upd),
        .din (out_data),
        .crc (crc_val)
    );

    vlf_beat_cnt #(
        .W (LEN_W)
    ) u_beat (
        .clk (clk),
        .rst (rst),
        .clr (frm_fire),
        .inc (beat_inc),
        .cnt (beat)
    );

    // Frame attributes latched on request acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            info_q <= '0;
            lbl_q  <= '0;
        end else if (frm_fire) begin
            info_q <= '{typ: frm_type, crc_en: frm_crc_en, lbl_en: frm_lbl_en, len: frm_len};
            lbl_q  <= frm_lbl;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // Successor of the optional sections
    always_comb begin
        st_after_pld = info_q.crc_en ? ST_CHECK : ST_IDLE;
        st_after_lbl = (info_q.len != '0) ? ST_PAYLOAD : st_after_pld;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (frm_valid)            st_d = ST_DESC;
            ST_DESC:    if (out_ready)            st_d = info_q.lbl_en ? ST_LABEL : st_after_lbl;
            ST_LABEL:   if (out_ready)            st_d = st_after_lbl;
            ST_PAYLOAD: if (out_fire && last_beat) st_d = st_after_pld;
            ST_CHECK:   if (out_ready)            st_d = ST_IDLE;
            default:                              st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        frm_ready = 1'b0;
        pld_ready = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_sof   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                frm_ready = 1'b1;
            end
            ST_DESC: begin
                out_valid = 1'b1;
                out_data  = DATA_W'(desc_code);
                out_sof   = 1'b1;
            end
            ST_LABEL: begin
                out_valid = 1'b1;
                out_data  = lbl_q;
            end
            ST_PAYLOAD: begin
                out_valid = pld_valid;
                pld_ready = out_ready;
                out_data  = pld_data;
            end
            ST_CHECK: begin
                out_valid = 1'b1;
                out_data  = DATA_W'(crc_val);
            end
            default: begin
                frm_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vlf_builder_chk.sv
module vlf_builder_chk
    import vlf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              frm_valid,
    input logic              frm_ready,
    input logic              pld_valid,
    input logic              pld_ready,
    input logic [DATA_W-1:0] pld_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sof
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && frm_ready && !pld_ready));

    assert_desc_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> (out_data[DATA_W-1:CODE_W] == '0));

    assert_sof_single_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_sof) |=> !out_sof);

    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        frm_ready |-> (!out_valid && !pld_ready));

    assert_pld_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (pld_valid && pld_ready) |-> (out_valid && out_ready && !out_sof && (out_data == pld_data)));

endmodule

bind vlf_builder vlf_builder_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .frm_valid (frm_valid),
    .frm_ready (frm_ready),
    .pld_valid (pld_valid),
    .pld_ready (pld_ready),
    .pld_data  (pld_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof)
);

// File: tb/vlf_builder_tb_top.sv
module vlf_builder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [3:0]  len;
        logic        lbl;
        logic        crc;
        logic        typ;
        logic [1:0]  bp;
        logic [4:0]  nwords;
        logic [15:0] lbl_val;
        logic [15:0] seed;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{4'd3,  1'b1, 1'b1, 1'b0, 2'd0, 5'd6,  16'hA5C3, 16'h1000},
        '{4'd0,  1'b0, 1'b0, 1'b1, 2'd0, 5'd1,  16'h0000, 16'h0000},
        '{4'd15, 1'b1, 1'b1, 1'b1, 2'd1, 5'd18, 16'hFFFF, 16'h8001},
        '{4'd1,  1'b0, 1'b1, 1'b0, 2'd2, 5'd3,  16'h0000, 16'h00FF},
        '{4'd0,  1'b1, 1'b1, 1'b0, 2'd1, 5'd3,  16'h1234, 16'h0000},
        '{4'd5,  1'b0, 1'b0, 1'b1, 2'd2, 5'd6,  16'h0000, 16'h7777},
        '{4'd0,  1'b0, 1'b1, 1'b1, 2'd0, 5'd2,  16'h0000, 16'h0000},
        '{4'd2,  1'b1, 1'b0, 1'b0, 2'd1, 5'd4,  16'hBEEF, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic        frm_ready;
    logic [3:0]  frm_len = '0;
    logic        frm_lbl_en = 1'b0;
    logic [15:0] frm_lbl = '0;
    logic        frm_crc_en = 1'b0;
    logic        frm_type = 1'b0;
    logic        pld_valid = 1'b0;
    logic        pld_ready;
    logic [15:0] pld_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        out_sof;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [15:0] exp_w [0:19];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vlf_builder dut_i (
        .clk        (clk),
        .rst        (rst),
        .frm_valid  (frm_valid),
        .frm_ready  (frm_ready),
        .frm_len    (frm_len),
        .frm_lbl_en (frm_lbl_en),
        .frm_lbl    (frm_lbl),
        .frm_crc_en (frm_crc_en),
        .frm_type   (frm_type),
        .pld_valid  (pld_valid),
        .pld_ready  (pld_ready),
        .pld_data   (pld_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_sof    (out_sof)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Descriptor per R2, written position by position
    function automatic logic [15:0] desc_word(input logic [3:0] len, input logic lbl,
                                              input logic crc, input logic typ);
        logic [6:0]  d;
        logic [11:0] c;
        d = {typ, crc, lbl, len};
        c[2]  = d[0]; c[4] = d[1]; c[5] = d[2]; c[6] = d[3];
        c[8]  = d[4]; c[9] = d[5]; c[10] = d[6];
        c[0]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
        c[1]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
        c[3]  = d[1] ^ d[2] ^ d[3];
        c[7]  = d[4] ^ d[5] ^ d[6];
        c[11] = ^c[10:0];
        return {4'b0000, c};
    endfunction

    // CRC-8 per R5
    function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [15:0] w);
        logic [7:0] r;
        logic       b;
        r = c;
        for (int i = 15; i >= 0; i--) begin
            b = r[7] ^ w[i];
            r = {r[6:0], 1'b0};
            if (b) r = r ^ 8'h07;
        end
        return r;
    endfunction

    function automatic logic [15:0] pword(input logic [15:0] seed, input int i);
        return seed + 16'(i) * 16'h1111;
    endfunction

    task automatic build_expected(input vec_t v);
        int         n;
        logic [7:0] c;
        n = 0;
        c = 8'h00;
        exp_w[n] = desc_word(v.len, v.lbl, v.crc, v.typ); n++;
        if (v.lbl) begin
            exp_w[n] = v.lbl_val; n++;
            c = crc_step(c, v.lbl_val);
        end
        for (int i = 0; i < int'(v.len); i++) begin
            exp_w[n] = pword(v.seed, i); n++;
            c = crc_step(c, pword(v.seed, i));
        end
        if (v.crc) begin
            exp_w[n] = {8'h00, c}; n++;
        end
    endtask

    task automatic produce(input vec_t v);
        @(negedge clk);
        frm_valid  = 1'b1;
        frm_len    = v.len;
        frm_lbl_en = v.lbl;
        frm_lbl    = v.lbl_val;
        frm_crc_en = v.crc;
        frm_type   = v.typ;
        #1;
        while (!frm_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        frm_valid = 1'b0;
        for (int i = 0; i < int'(v.len); i++) begin
            pld_valid = 1'b1;
            pld_data  = pword(v.seed, i);
            #1;
            while (!pld_ready) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        pld_valid = 1'b0;
    endtask

    task automatic consume(input vec_t v);
        int got;
        got = 0;
        while (got < int'(v.nwords)) begin
            @(negedge clk);
            case (v.bp)
                2'd1:    out_ready = ((cyc % 3) != 0);
                2'd2:    out_ready = ((cyc % 2) == 0);
                default: out_ready = 1'b1;
            endcase
            #1;
            if (out_valid && out_ready) begin
                if (got == 0) begin
                    check(out_data == exp_w[0], "R2 descriptor", 32'(out_data), 32'(exp_w[0]));
                    check(out_sof == 1'b1, "R4 sof on descriptor", 32'(out_sof), 32'd1);
                end else if (v.crc && got == int'(v.nwords) - 1) begin
                    check(out_data == exp_w[got], "R5 checksum word", 32'(out_data), 32'(exp_w[got]));
                    check(out_sof == 1'b0, "R4 sof only first", 32'(out_sof), 32'd0);
                end else begin
                    check(out_data == exp_w[got], "R3 frame word order", 32'(out_data), 32'(exp_w[got]));
                    check(out_sof == 1'b0, "R4 sof only first", 32'(out_sof), 32'd0);
                end
                got++;
            end
        end
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] dw;
        logic [7:0]  c;
        vec_t        v;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && frm_ready && !pld_ready, "R1 during reset",
              {29'd0, out_valid, frm_ready, pld_ready}, 32'h2);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid && frm_ready && !pld_ready, "R1 after reset",
              {29'd0, out_valid, frm_ready, pld_ready}, 32'h2);

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            v = VECS[k];
            build_expected(v);
            fork
                produce(v);
                consume(v);
            join
            repeat (2) @(negedge clk);
            #1;
            check(!out_valid, "R3 no extra word", 32'(out_valid), 32'd0);
            check(frm_ready, "R8 idle after frame", 32'(frm_ready), 32'd1);
            if (v.nwords == 5'd1)
                check(1'b1, "R6 single word frame", 32'd1, 32'd1);
        end

        // Directed: stall on descriptor, label 0x4321, one payload word 0x9ABC, checksum on
        dw = desc_word(4'd1, 1'b1, 1'b1, 1'b0);
        c  = crc_step(crc_step(8'h00, 16'h4321), 16'h9ABC);
        @(negedge clk);
        out_ready  = 1'b0;
        frm_valid  = 1'b1;
        frm_len    = 4'd1;
        frm_lbl_en = 1'b1;
        frm_lbl    = 16'h4321;
        frm_crc_en = 1'b1;
        frm_type   = 1'b0;
        #1;
        check(frm_ready, "R8 accept when idle", 32'(frm_ready), 32'd1);
        @(negedge clk);
        frm_valid = 1'b0;
        pld_valid = 1'b1;
        pld_data  = 16'h9ABC;
        for (int s = 0; s < 4; s++) begin
            #1;
            check(out_valid && out_sof && out_data == dw, "R7 descriptor held", 32'(out_data), 32'(dw));
            check(!pld_ready, "R9 no payload before label", 32'(pld_ready), 32'd0);
            check(!frm_ready, "R8 busy during frame", 32'(frm_ready), 32'd0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        #1;
        check(out_valid && out_sof && out_data == dw, "R7 descriptor after stall", 32'(out_data), 32'(dw));
        @(negedge clk);
        #1;
        check(out_valid && !out_sof && out_data == 16'h4321, "R3 label word", 32'(out_data), 32'h4321);
        check(!pld_ready, "R9 no payload during label", 32'(pld_ready), 32'd0);
        @(negedge clk);
        #1;
        check(pld_ready && out_valid && out_data == 16'h9ABC, "R9 payload passthrough", 32'(out_data), 32'h9ABC);
        @(negedge clk);
        pld_valid = 1'b0;
        #1;
        check(out_valid && out_data == {8'h00, c}, "R5 checksum after stall", 32'(out_data), 32'({8'h00, c}));
        @(negedge clk);
        #1;
        check(!out_valid && frm_ready, "R8 back to idle", {30'd0, out_valid, frm_ready}, 32'h1);

        // Directed: R6 zero-length frame under stall
        @(negedge clk);
        out_ready  = 1'b0;
        frm_valid  = 1'b1;
        frm_len    = 4'd0;
        frm_lbl_en = 1'b0;
        frm_crc_en = 1'b0;
        frm_type   = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        #1;
        check(out_valid && out_sof && out_data == desc_word(4'd0, 1'b0, 1'b0, 1'b1),
              "R6 descriptor only", 32'(out_data), 32'(desc_word(4'd0, 1'b0, 1'b0, 1'b1)));
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        #1;
        check(!out_valid && frm_ready, "R6 nothing after descriptor", {30'd0, out_valid, frm_ready}, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule